// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block shifts a 16-bit or 32-bit destination operand left or right and fills the vacated bit positions from a second operand, the source, rather than with zeros or with the bits that fall off the word. A left shift takes its fill bits from the top of the source. A right shift takes them from the bottom of the source. The source is only read, and the block returns a single result word.

The block sits in an execution pipe after decode. The shift count arrives already selected, either from an immediate field or from a count register. The block masks the count to five bits. It drives the sign and zero flags from the result and reports which flags it wrote through a mask. The remaining arithmetic flags have no defined value after this operation, so the block drives them to zero and leaves them out of the mask. The result and flags are registered, so they appear one cycle after the operands.

Top module: `fsh_top`

## Requirements
- R1: In 32-bit mode (size_i=1) with a left shift (dir_i=0) and masked count n>0, res_o holds dst_i shifted left by n, with bits n-1..0 taken from src_i bits 31..32-n.
- R2: In 32-bit mode with a right shift (dir_i=1) and masked count n>0, res_o holds dst_i shifted right by n, with bits 31..32-n taken from src_i bits n-1..0.
- R3: In 16-bit mode (size_i=0) the shift works on the low 16 bits of both operands in the same way as R1 and R2, and res_o[31:16] is always 0. A count of 16 returns src_i[15:0].
- R4: Only cnt_i[4:0] is used as the count. Bits above bit 4 have no effect.
- R5: A masked count of 0 returns the destination unchanged (the low half with a zero upper half in 16-bit mode), with flag_wr_o=0 and sf_o=zf_o=0.
- R6: In 16-bit mode a masked count above 16 gives res_o=0, flag_wr_o=0 and sf_o=zf_o=0.
- R7: When flags are written, sf_o is the top bit of the operand-size result, zf_o is 1 exactly when that result is zero, and flag_wr_o=6'b011000 (bit 4 sign, bit 3 zero; bit 0 carry, 1 parity, 2 auxiliary, 5 overflow).
- R8: undef_flags_o (overflow, auxiliary, parity, carry) is always 0, and those flags' bits in flag_wr_o are never set.
- R9: Outputs are registered with one cycle of latency. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dst_i | input | 32 | Destination operand that is shifted |
| src_i | input | 32 | Source operand that supplies the fill bits |
| cnt_i | input | 8 | Shift count; only the low 5 bits are used |
| dir_i | input | 1 | 0 for a left shift, 1 for a right shift |
| size_i | input | 1 | 0 for 16-bit operands, 1 for 32-bit operands |
| res_o | output | 32 | Shifted result |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| undef_flags_o | output | 4 | Overflow, auxiliary, parity and carry flags, always 0 |
| flag_wr_o | output | 6 | Mask of the flags that were written |

## Verification
The shift is tried with walking-one and mixed operands whose destination and source bits cannot be confused, so a fill taken from the wrong end of the source, or from zeros, shows up as a different result. Counts of 1, mid-range values and the largest count for each size separate errors of one bit position from wrong direction or width selection. Counts with bits set above bit 4 show whether the masking is applied. The counts 0, 16 and 17 to 31 in 16-bit mode distinguish the pass-through, full-replacement and out-of-range paths. Results chosen to be negative or zero tell a correct flag source apart from one taken at the wrong width.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic {DIR_LEFT = 1'b0, DIR_RIGHT = 1'b1} dir_e;
  typedef enum logic {SZ_16 = 1'b0, SZ_32 = 1'b1} size_e;

  // flag-mask bit positions
  localparam int unsigned FB_CF = 0;
  localparam int unsigned FB_PF = 1;
  localparam int unsigned FB_AF = 2;
  localparam int unsigned FB_ZF = 3;
  localparam int unsigned FB_SF = 4;
  localparam int unsigned FB_OF = 5;
  localparam int unsigned FLAG_N = 6;
endpackage

// File: rtl/fsh_count.sv
module fsh_count #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_IN_W = 8,
  localparam int unsigned CNT_W   = $clog2(DATA_W),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input  logic [CNT_IN_W-1:0] cnt_i,
  input  logic                size_i,
  output logic [CNT_W-1:0]    amt_o,
  output logic                pass_o,
  output logic                over_o
);
  import fsh_pkg::*;

  assign amt_o  = cnt_i[CNT_W-1:0];
  assign pass_o = (amt_o == '0);
  assign over_o = (size_i == SZ_16) && (int'(amt_o) > HALF_W);
endmodule

// File: rtl/fsh_lane.sv
module fsh_lane #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned AMT_W  = 5
) (
  input  logic [LANE_W-1:0] dst_i,
  input  logic [LANE_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              dir_i,
  output logic [LANE_W-1:0] res_o
);
  import fsh_pkg::*;

  logic [2*LANE_W-1:0] cat_l, cat_r;

  // left: dst on top, source MSBs follow in; right: source LSBs sit above dst
  assign cat_l = {dst_i, src_i} << amt_i;
  assign cat_r = {src_i, dst_i} >> amt_i;
  assign res_o = (dir_i == DIR_RIGHT) ? cat_r[LANE_W-1:0] : cat_l[2*LANE_W-1:LANE_W];
endmodule

// File: rtl/fsh_flags.sv
module fsh_flags #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic                       wr_en_i,
  input  logic                       size_i,
  input  logic [DATA_W-1:0]          res_i,
  output logic                       sf_o,
  output logic                       zf_o,
  output logic [3:0]                 undef_o,
  output logic [fsh_pkg::FLAG_N-1:0] mask_o
);
  import fsh_pkg::*;

  logic msb, is_zero;

  always_comb begin
    if (size_i == SZ_32) begin
      msb     = res_i[DATA_W-1];
      is_zero = (res_i == '0);
    end else begin
      msb     = res_i[HALF_W-1];
      is_zero = (res_i[HALF_W-1:0] == '0);
    end
  end

  assign sf_o    = wr_en_i & msb;
  assign zf_o    = wr_en_i & is_zero;
  assign undef_o = '0;

  always_comb begin
    mask_o        = '0;
    mask_o[FB_SF] = wr_en_i;
    mask_o[FB_ZF] = wr_en_i;
  end
endmodule

// File: rtl/fsh_top.sv
module fsh_top #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_IN_W = 8,
  localparam int unsigned CNT_W   = $clog2(DATA_W),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [DATA_W-1:0]          dst_i,
  input  logic [DATA_W-1:0]          src_i,
  input  logic [CNT_IN_W-1:0]        cnt_i,
  input  logic                       dir_i,
  input  logic                       size_i,
  output logic [DATA_W-1:0]          res_o,
  output logic                       sf_o,
  output logic                       zf_o,
  output logic [3:0]                 undef_flags_o,
  output logic [fsh_pkg::FLAG_N-1:0] flag_wr_o
);
  import fsh_pkg::*;

  logic [CNT_W-1:0]  amt;
  logic              pass, over, wr_en;
  logic [DATA_W-1:0] lane_res [2];
  logic [DATA_W-1:0] res_n;
  logic              sf_n, zf_n;
  logic [3:0]        undef_n;
  logic [FLAG_N-1:0] mask_n;

  fsh_count #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_count (
    .cnt_i (cnt_i),
    .size_i(size_i),
    .amt_o (amt),
    .pass_o(pass),
    .over_o(over)
  );

  // lane 0: half width, lane 1: full width
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int unsigned LW = (g == 0) ? HALF_W : DATA_W;
    logic [LW-1:0] lres;
    fsh_lane #(.LANE_W(LW), .AMT_W(CNT_W)) u_lane (
      .dst_i(dst_i[LW-1:0]),
      .src_i(src_i[LW-1:0]),
      .amt_i(amt),
      .dir_i(dir_i),
      .res_o(lres)
    );
    if (LW < DATA_W) begin : g_pad
      assign lane_res[g] = {{(DATA_W-LW){1'b0}}, lres};
    end else begin : g_full
      assign lane_res[g] = lres;
    end
  end

  always_comb begin
    if (pass)      res_n = (size_i == SZ_32) ? dst_i : {{HALF_W{1'b0}}, dst_i[HALF_W-1:0]};
    else if (over) res_n = '0;
    else           res_n = lane_res[size_i];
  end

  assign wr_en = !pass && !over;

  fsh_flags #(.DATA_W(DATA_W)) u_flags (
    .wr_en_i(wr_en),
    .size_i (size_i),
    .res_i  (res_n),
    .sf_o   (sf_n),
    .zf_o   (zf_n),
    .undef_o(undef_n),
    .mask_o (mask_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o         <= '0;
      sf_o          <= 1'b0;
      zf_o          <= 1'b0;
      undef_flags_o <= '0;
      flag_wr_o     <= '0;
    end else begin
      res_o         <= res_n;
      sf_o          <= sf_n;
      zf_o          <= zf_n;
      undef_flags_o <= undef_n;
      flag_wr_o     <= mask_n;
    end
  end
endmodule

// File: rtl/fsh_chk.sv
module fsh_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_IN_W = 8,
  localparam int unsigned CNT_W   = $clog2(DATA_W),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [DATA_W-1:0]          dst_i,
  input logic [DATA_W-1:0]          src_i,
  input logic [CNT_IN_W-1:0]        cnt_i,
  input logic                       dir_i,
  input logic                       size_i,
  input logic [DATA_W-1:0]          res_o,
  input logic                       sf_o,
  input logic                       zf_o,
  input logic [3:0]                 undef_flags_o,
  input logic [fsh_pkg::FLAG_N-1:0] flag_wr_o
);
  p_left_fill_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i && !dir_i && cnt_i[CNT_W-1:0] == 1)
    |=> res_o == {$past(dst_i[DATA_W-2:0]), $past(src_i[DATA_W-1])});

  p_right_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i && dir_i && cnt_i[CNT_W-1:0] == 1)
    |=> res_o == {$past(src_i[0]), $past(dst_i[DATA_W-1:1])});

  p_upper_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size_i |=> res_o[DATA_W-1:HALF_W] == '0);

  p_pass_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i && cnt_i[CNT_W-1:0] == 0) |=> (res_o == $past(dst_i) && flag_wr_o == '0));

  p_quiet_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_o == '0) |-> (!sf_o && !zf_o));

  p_over_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!size_i && int'(cnt_i[CNT_W-1:0]) > HALF_W) |=> (res_o == '0 && flag_wr_o == '0));

  p_mask_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_o == '0 || flag_wr_o == 6'b011000));

  p_undef_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_o != '0 |-> undef_flags_o == '0);
endmodule

bind fsh_top fsh_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_fsh_chk (.*);

// File: tb/sim_fsh_top.sv
`timescale 1ns/1ps
module sim_fsh_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dst = '0, src = '0;
  logic [7:0]  cnt = '0;
  logic        dir = 1'b0, size = 1'b0;
  logic [31:0] res;
  logic        sf, zf;
  logic [3:0]  undef;
  logic [5:0]  fwr;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fsh_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .dst_i(dst), .src_i(src), .cnt_i(cnt),
    .dir_i(dir), .size_i(size), .res_o(res), .sf_o(sf), .zf_o(zf),
    .undef_flags_o(undef), .flag_wr_o(fwr)
  );

  // bitwise reference, built from the requirement text
  task automatic model(input logic [31:0] d, input logic [31:0] s, input logic [7:0] c,
                       input logic dr, input logic sz, output logic [31:0] r,
                       output logic esf, output logic ezf, output logic [5:0] em);
    int n = int'(c & 8'h1f);
    int lw = sz ? 32 : 16;
    logic wr = 1'b1;
    r = '0;
    if (n == 0) begin
      wr = 1'b0;
      for (int i = 0; i < lw; i++) r[i] = d[i];
    end else if (!sz && n > 16) begin
      wr = 1'b0;
    end else begin
      for (int i = 0; i < lw; i++) begin
        if (!dr) r[i] = (i >= n) ? d[i-n] : s[lw-n+i];
        else     r[i] = (i + n < lw) ? d[i+n] : s[i+n-lw];
      end
    end
    esf = wr & r[lw-1];
    ezf = wr & (r == '0);
    em  = wr ? 6'b011000 : 6'b000000;
  endtask

  task automatic apply(input logic [31:0] d, input logic [31:0] s, input logic [7:0] c,
                       input logic dr, input logic sz, input string tag);
    logic [31:0] er;
    logic esf, ezf;
    logic [5:0] em;
    model(d, s, c, dr, sz, er, esf, ezf, em);
    @(negedge clk);
    dst = d; src = s; cnt = c; dir = dr; size = sz;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (res !== er || sf !== esf || zf !== ezf || fwr !== em || undef !== 4'h0) begin
      errors++;
      $display("FAIL %s: res=%h sf=%b zf=%b wr=%b undef=%h expected res=%h sf=%b zf=%b wr=%b undef=0",
               tag, res, sf, zf, fwr, undef, er, esf, ezf, em);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (res !== '0 || sf !== 1'b0 || zf !== 1'b0 || fwr !== '0 || undef !== '0) begin
      errors++;
      $display("FAIL R9 reset: res=%h sf=%b zf=%b wr=%b undef=%h expected all 0",
               res, sf, zf, fwr, undef);
    end
  endtask

  task automatic t_left32;
    apply(32'h8000_0001, 32'hC000_0000, 8'd1, 1'b0, 1'b1, "R1 left32 n=1");
    apply(32'h1234_5678, 32'h9ABC_DEF0, 8'd8, 1'b0, 1'b1, "R1 left32 n=8");
    apply(32'h0000_0001, 32'hFFFF_FFFE, 8'd31, 1'b0, 1'b1, "R1 left32 n=31");
  endtask

  task automatic t_right32;
    apply(32'h8000_0001, 32'h0000_0003, 8'd1, 1'b1, 1'b1, "R2 right32 n=1");
    apply(32'h1234_5678, 32'h9ABC_DEF0, 8'd12, 1'b1, 1'b1, "R2 right32 n=12");
    apply(32'hFFFF_FFFF, 32'h0000_0001, 8'd31, 1'b1, 1'b1, "R2 right32 n=31");
  endtask

  task automatic t_half;
    apply(32'hDEAD_1234, 32'hBEEF_ABCD, 8'd4, 1'b0, 1'b0, "R3 left16 n=4");
    apply(32'hDEAD_1234, 32'hBEEF_ABCD, 8'd4, 1'b1, 1'b0, "R3 right16 n=4");
    apply(32'hFFFF_0F0F, 32'h5555_A5A5, 8'd16, 1'b0, 1'b0, "R3 left16 n=16");
    apply(32'hFFFF_0F0F, 32'h5555_A5A5, 8'd16, 1'b1, 1'b0, "R3 right16 n=16");
  endtask

  task automatic t_mask;
    apply(32'h1234_5678, 32'hFFFF_FFFF, 8'h21, 1'b0, 1'b1, "R4 cnt 0x21 acts as 1");
    apply(32'h1234_5678, 32'h0000_0000, 8'hE4, 1'b1, 1'b1, "R4 cnt 0xE4 acts as 4");
    apply(32'hCAFE_F00D, 32'h1111_1111, 8'h20, 1'b0, 1'b1, "R4 R5 cnt 0x20 acts as 0");
  endtask

  task automatic t_zero_cnt;
    apply(32'h8765_4321, 32'hFFFF_FFFF, 8'd0, 1'b0, 1'b1, "R5 zero count 32");
    apply(32'h8765_8321, 32'hFFFF_FFFF, 8'd0, 1'b1, 1'b0, "R5 zero count 16");
  endtask

  task automatic t_over16;
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd17, 1'b0, 1'b0, "R6 left16 n=17");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd31, 1'b1, 1'b0, "R6 right16 n=31");
  endtask

  task automatic t_flags;
    apply(32'h0000_0000, 32'h0000_0000, 8'd5, 1'b0, 1'b1, "R7 zero result 32");
    apply(32'h4000_0000, 32'h0000_0000, 8'd1, 1'b0, 1'b1, "R7 negative result 32");
    apply(32'hFFFF_4000, 32'hFFFF_0000, 8'd1, 1'b0, 1'b0, "R7 R8 negative result 16");
    apply(32'hFFFF_8000, 32'hFFFF_0000, 8'd16, 1'b1, 1'b0, "R7 R8 zero result 16");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_left32();
    t_right32();
    t_half();
    t_mask();
    t_zero_cnt();
    t_over16();
    t_flags();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule